// File: doc/BRIEF.md
# Lottery Number Draw Controller

This block runs a six-number lottery draw with values from 1 to 49. A draw counter runs while a push button is held. When the button is let go, the counter stops, and the block checks the stopped value against the numbers it has already kept. A value that has not been seen is written into the next free result slot, and the green indicator lights. A value that has been seen before is thrown away, and the red indicator lights so that the operator draws again.

Once the sixth distinct number is stored, the block enters an end state. In that state the red and green indicators take turns. The lit indicator swaps on every pulse of a slow tick input, so a tick rate of about 2 Hz gives each colour half a second. Only the synchronous active-low reset leaves the end state. The button input must already be debounced. Driving the six stored values onto a display is done by logic outside this block.

Top module: `lotto_draw_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every result slot is cleared to 0, both indicators go off, the fill count goes to 0 and the draw counter loads 1.
- R2: At each clock edge where `button` is 1, the draw counter steps by one from 1 up to 49, and 49 is followed by 1.
- R3: At each clock edge where `button` is 0, the draw counter keeps its value.
- R4: A release is the edge where the registered copy of `button` is 1 and `button` is 0. If the counter value at a release matches no slot that has been filled, it is written into slot k. Here k is the number of slots already filled, and slot k sits at `results[6k+5:6k]`. After that edge `led_green` is 1 and `led_red` is 0.
- R5: If the counter value at a release equals a number already stored, no slot changes, and after that edge `led_red` is 1 and `led_green` is 0.
- R6: After the edge that stores the sixth number, the block is in the end state with `led_green` 1 and `led_red` 0. Each clock edge with `tick` at 1 swaps the two indicators.
- R7: In the end state, further presses and releases change neither the stored numbers nor the indicators.
- R8: Outside the end state, `tick` has no effect on the indicators.
- R9: `led_red` and `led_green` are never both 1, and before the first release both are 0.
- R10: Asserting reset during a draw or in the end state brings the block back to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Slow enable pulse, one clock wide, that swaps the indicators in the end state |
| button | input | 1 | Debounced draw button, 1 while held |
| led_red | output | 1 | Redraw indicator |
| led_green | output | 1 | Accepted or next-draw indicator |
| results | output | 36 | Six stored numbers of 6 bits each; slot 0 in the lowest bits |

## Verification
The assertions assume that `button` is a clean level that changes only between clock edges. They also assume that `tick` is a single-cycle pulse, because every edge that sees `tick` high counts as a swap. The stimulus drives `button` and `tick` on the falling clock edge and holds each press for a random whole number of cycles. It uses `tick` only as one-cycle pulses. Some of the press lengths are chosen so that the counter lands exactly on a number already stored, and others so that it wraps past 49.

// File: rtl/lotto_pkg.sv
// Package: shared constants and the indicator state type for the draw controller.
// Assumes: values fit in 6 bits, so the largest drawable number is at most 63.
package lotto_pkg;
    localparam int unsigned LOTTO_MAX_VAL = 49;
    localparam int unsigned LOTTO_SLOTS   = 6;

    typedef enum logic [1:0] {
        IND_OFF   = 2'd0,
        IND_GREEN = 2'd1,
        IND_RED   = 2'd2,
        IND_END   = 2'd3
    } ind_state_e;
endpackage

// File: rtl/lotto_draw_counter.sv
// Module: cyclic draw counter running from 1 to MAX_VAL.
// Assumes: advance is a synchronous level; reset is synchronous and active low.
module lotto_draw_counter #(
    parameter int unsigned MAX_VAL = 49,
    parameter int unsigned VAL_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [VAL_W-1:0] value
);
    localparam logic [VAL_W-1:0] TOP_VAL = VAL_W'(MAX_VAL);
    localparam logic [VAL_W-1:0] ONE_VAL = VAL_W'(1);

    // Step while advance is high, wrap from the top value to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= ONE_VAL;
        end else if (advance) begin
            value <= (value == TOP_VAL) ? ONE_VAL : value + ONE_VAL;
        end
    end
endmodule

// File: rtl/lotto_result_bank.sv
// Module: result slots with a fill index and a duplicate search over filled slots.
// Assumes: wr_en is only raised while fill < SLOTS and no duplicate is found.
module lotto_result_bank #(
    parameter int unsigned SLOTS = 6,
    parameter int unsigned VAL_W = 6,
    parameter int unsigned IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [VAL_W-1:0]       probe,
    output logic                   dup,
    output logic [IDX_W-1:0]       fill,
    output logic [SLOTS*VAL_W-1:0] results
);
    logic [SLOTS-1:0] hit;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [VAL_W-1:0] slot_q;

        // Capture the probe into this slot when it is the next free one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (fill == IDX_W'(i))) begin
                slot_q <= probe;
            end
        end

        assign hit[i] = (IDX_W'(i) < fill) && (slot_q == probe);
        assign results[i*VAL_W +: VAL_W] = slot_q;
    end

    assign dup = |hit;

    // Count the filled slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (wr_en) begin
            fill <= fill + IDX_W'(1);
        end
    end
endmodule

// File: rtl/lotto_indicator.sv
// Module: indicator state machine for accepted, redraw and end-of-draw display.
// Assumes: eval is a one-cycle pulse; tick is a one-cycle pulse at twice the swap rate wanted per colour.
module lotto_indicator (
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic dup,
    input  logic last,
    input  logic tick,
    output logic done,
    output logic led_red,
    output logic led_green
);
    import lotto_pkg::*;

    ind_state_e state;
    logic       phase;

    // Move between off, accepted, redraw and the terminal end state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= IND_OFF;
        end else if (eval && (state != IND_END)) begin
            if (dup) begin
                state <= IND_RED;
            end else if (last) begin
                state <= IND_END;
            end else begin
                state <= IND_GREEN;
            end
        end
    end

    // Toggle the alternation phase on each tick while in the end state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else if ((state == IND_END) && tick) begin
            phase <= ~phase;
        end
    end

    assign done      = (state == IND_END);
    assign led_green = (state == IND_GREEN) || (done && !phase);
    assign led_red   = (state == IND_RED)   || (done &&  phase);
endmodule

// File: rtl/lotto_draw_ctrl.sv
// Module: top of the lottery draw controller.
// Assumes: button is debounced and synchronous to clk; reset is synchronous and active low.
module lotto_draw_ctrl #(
    parameter int unsigned MAX_VAL = lotto_pkg::LOTTO_MAX_VAL,
    parameter int unsigned SLOTS   = lotto_pkg::LOTTO_SLOTS,
    parameter int unsigned VAL_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   button,
    output logic                   led_red,
    output logic                   led_green,
    output logic [SLOTS*VAL_W-1:0] results
);
    localparam int unsigned IDX_W = $clog2(SLOTS + 1);

    logic             btn_q;
    logic             release_evt;
    logic [VAL_W-1:0] draw_val;
    logic [IDX_W-1:0] fill;
    logic             dup;
    logic             done;
    logic             store;

    // Keep a registered copy of the button for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            btn_q <= 1'b0;
        end else begin
            btn_q <= button;
        end
    end

    assign release_evt = btn_q && !button;
    assign store       = release_evt && !done && !dup;

    lotto_draw_counter #(.MAX_VAL(MAX_VAL), .VAL_W(VAL_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (button),
        .value   (draw_val)
    );

    lotto_result_bank #(.SLOTS(SLOTS), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store),
        .probe   (draw_val),
        .dup     (dup),
        .fill    (fill),
        .results (results)
    );

    lotto_indicator u_ind (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval      (release_evt),
        .dup       (dup),
        .last      (fill == IDX_W'(SLOTS - 1)),
        .tick      (tick),
        .done      (done),
        .led_red   (led_red),
        .led_green (led_green)
    );
endmodule

// File: rtl/lotto_draw_chk.sv
// Module: property checker bound to the draw controller.
// Assumes: button and tick change only between clock edges.
module lotto_draw_chk #(
    parameter int unsigned MAX_VAL = 49,
    parameter int unsigned SLOTS   = 6,
    parameter int unsigned VAL_W   = 6,
    parameter int unsigned IDX_W   = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   button,
    input logic                   led_red,
    input logic                   led_green,
    input logic [SLOTS*VAL_W-1:0] results,
    input logic [VAL_W-1:0]       draw_val,
    input logic [IDX_W-1:0]       fill
);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_val >= VAL_W'(1)) && (draw_val <= VAL_W'(MAX_VAL)));

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (button && draw_val == VAL_W'(MAX_VAL)) |=> (draw_val == VAL_W'(1)));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !button |=> $stable(draw_val));

    // R9
    led_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(led_red && led_green));

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= IDX_W'(SLOTS));

    // R7
    end_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == IDX_W'(SLOTS)) |=> $stable(results));

    // R6
    end_leds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == IDX_W'(SLOTS)) |-> (led_red != led_green));
endmodule

bind lotto_draw_ctrl lotto_draw_chk #(
    .MAX_VAL(MAX_VAL), .SLOTS(SLOTS), .VAL_W(VAL_W), .IDX_W(IDX_W)
) u_lotto_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .button    (button),
    .led_red   (led_red),
    .led_green (led_green),
    .results   (results),
    .draw_val  (draw_val),
    .fill      (fill)
);

// File: tb/test_lotto_draw_ctrl.sv
module test_lotto_draw_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV  = 49;
    localparam int NSL   = 6;
    localparam int VW    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic button = 1'b0;
    logic led_red;
    logic led_green;
    logic [NSL*VW-1:0] results;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int m_cnt;
    int m_fill;
    int m_vals [NSL];
    bit m_red, m_green, m_done, m_phase;

    lotto_draw_ctrl i_lotto_draw_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .button(button),
        .led_red(led_red), .led_green(led_green), .results(results)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int step_cnt(int c, int n);
        return ((c - 1 + n) % MAXV) + 1;
    endfunction

    function automatic logic [NSL*VW-1:0] exp_results();
        logic [NSL*VW-1:0] v = '0;
        for (int k = 0; k < NSL; k++) v[k*VW +: VW] = VW'(m_vals[k]);
        return v;
    endfunction

    function automatic bit is_dup(int v);
        for (int k = 0; k < NSL; k++) if (k < m_fill && m_vals[k] == v) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_val(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check_val({tag, " results"}, 64'(results), 64'(exp_results()));
        check_val({tag, " led_red"}, 64'(led_red), 64'(m_red));
        check_val({tag, " led_green"}, 64'(led_green), 64'(m_green));
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        button = 1'b0;
        tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 1; m_fill = 0; m_red = 0; m_green = 0; m_done = 0; m_phase = 0;
        for (int k = 0; k < NSL; k++) m_vals[k] = 0;
    endtask

    // Hold the button for n clock edges, release, and update the model.
    task automatic press(int n);
        @(negedge clk) button = 1'b1;
        repeat (n) @(negedge clk);
        button = 1'b0;
        @(negedge clk);
        m_cnt = step_cnt(m_cnt, n);
        if (!m_done) begin
            if (is_dup(m_cnt)) begin
                m_red = 1; m_green = 0;
            end else begin
                m_vals[m_fill] = m_cnt;
                m_fill++;
                if (m_fill == NSL) begin
                    m_done = 1; m_phase = 0;
                end
                m_red = 0; m_green = 1;
            end
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        if (m_done) begin
            m_phase = ~m_phase;
            m_red = m_phase; m_green = ~m_phase;
        end
    endtask

    function automatic int steps_to(int target);
        int n = (target - m_cnt + MAXV) % MAXV;
        return (n == 0) ? MAXV : n;
    endfunction

    // watchdog
    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: reset state
        check_all("R1 reset");
        // R9: no LED before first release
        check_val("R9 idle leds", 64'(led_red | led_green), 64'd0);

        // R8: tick outside end state has no effect
        pulse_tick();
        check_all("R8 tick idle");

        // R2 R4: directed draw reaching 49 exactly then wrap
        press(48);
        check_all("R2 R4 first draw to 49");
        press(3);
        check_all("R2 R4 wrap to 3");
        // R3: idle cycles do not move counter: duplicate via hold
        repeat (5) @(negedge clk);
        press(MAXV);
        check_all("R3 R5 full-cycle duplicate");
        pulse_tick();
        check_all("R8 tick in red state");
        press(steps_to(m_vals[0]));
        check_all("R5 duplicate of slot0");
        press(10); check_all("R4 draw");
        press(7);  check_all("R4 draw");
        press(20); check_all("R4 draw");
        pulse_tick();
        check_all("R8 tick in green state");
        press(steps_to(40));
        check_all("R6 sixth draw end state");
        pulse_tick(); check_all("R6 swap 1");
        pulse_tick(); check_all("R6 swap 2");
        pulse_tick(); check_all("R6 swap 3");
        press(5);  check_all("R7 press in end state");
        press(steps_to(1)); check_all("R7 press in end state 2");

        // R10: reset from end state
        do_reset();
        check_all("R10 reset from end");
        press(4); check_all("R4 after reset");
        press(2); check_all("R4 second");
        do_reset();
        check_all("R10 reset mid draw");

        // random games
        for (int g = 0; g < 12; g++) begin
            do_reset();
            for (int d = 0; d < 40 && !m_done; d++) begin
                int n;
                if (m_fill > 0 && ($urandom % 10) < 3)
                    n = steps_to(m_vals[$urandom % m_fill]);
                else
                    n = 1 + ($urandom % 110);
                press(n);
                check_all("R4 R5 random draw");
                if (($urandom % 4) == 0) begin
                    pulse_tick();
                    check_all("R6 R8 random tick");
                end
            end
            if (m_done) begin
                press(1 + ($urandom % 60));
                check_all("R7 random end press");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule